// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a binary counter, four bits wide by default. All of its state bits change together on the rising clock edge. It can be preset synchronously from a parallel data input, and a direction input chooses whether it counts up or down. It has two active-low count enables, and it counts only when both are low at a clock edge. The preset input is also active low, and it takes priority over counting.

An active-low carry output goes low while the count sits at its terminal value for the current direction: all ones when counting up, zero when counting down. Only the trailing enable gates this carry. The carry therefore works as a look-ahead signal: wire it into the trailing enable of the next stage, feed the other enable of every stage from one shared line, and the stages form a wider synchronous counter with no extra gating, in either direction. An asynchronous active-low clear is provided only to give simulation a known starting state.

Top module: `updn_cascade_ctr`

## Requirements
- R1: While `rst_n` is low, `q` is 0 at once, without waiting for a clock edge.
- R2: When `load_n` is low at a rising edge, `q` takes the value of `din` on that edge. This holds whatever the levels of `enp_n`, `ent_n` and `up`.
- R3: When `load_n` is high and either `enp_n` or `ent_n` is high at a rising edge, `q` keeps its value.
- R4: When `load_n` is high and both enables are low at a rising edge, `q` changes by one. It counts up when `up` is 1 and down when `up` is 0, modulo 2^WIDTH: all ones goes to 0 counting up, and 0 goes to all ones counting down.
- R5: `carry_n` is low exactly when `ent_n` is low and `q` is terminal for the current direction (all ones with `up`=1, 0 with `up`=0). `enp_n` has no effect on `carry_n`.
- R6: `carry_n` follows changes on `ent_n` and `up` combinationally, between clock edges.
- R7: Pulses on `load_n`, `din`, `enp_n`, `ent_n` or `up` that start and end between two rising edges leave `q` unchanged.
- R8: Two stages form one 8-bit counter when the carry of the low stage drives `ent_n` of the high stage and `enp_n` and the clock are shared. The 8-bit value is `{hi.q, lo.q}`, with bit 0 of `q` as the least significant bit. It wraps 255 to 0 counting up and 0 to 255 counting down.
- R9: Loading 13 and then counting gives this exact sequence: up through 14, 15, 0, 1, 2; hold at 2 while inhibited; down through 1, 0, 15, 14, 13. `carry_n` is low at 15 while counting up and at 0 while counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear to zero, active low (for simulation start-up) |
| load_n | input | 1 | Synchronous parallel preset, active low |
| din | input | WIDTH | Preset value |
| up | input | 1 | Count direction: 1 counts up, 0 counts down |
| enp_n | input | 1 | Parallel count enable, active low; does not affect the carry |
| ent_n | input | 1 | Trailing count enable, active low; also gates the carry |
| q | output | WIDTH | Count value |
| carry_n | output | 1 | Terminal-count carry, active low |

## Verification
The clocked assertions assume that every control input is settled at each rising edge. They also assume that `rst_n` is released away from an edge, so that a sample taken just after release sees the state the clear produced. The bench changes inputs only on falling edges or in the middle of a half period. It never moves anything on a rising edge, and it releases the clear on a falling edge. The mid-cycle pulse tests deliberately break the "held for the whole cycle" pattern. They still put every pulse well clear of the rising edge, so every edge samples a stable value.

// File: rtl/updn_cascade_ctr.sv
module updn_cascade_ctr #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up,
  input  logic             enp_n,
  input  logic             ent_n,
  output logic [WIDTH-1:0] q,
  output logic             carry_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             run;
  logic             at_end;
  logic [WIDTH-1:0] nxt;

  assign run     = !enp_n && !ent_n;
  assign nxt     = up ? q + ONE : q - ONE;
  assign at_end  = up ? (q == TOP) : (q == '0);
  assign carry_n = !(at_end && !ent_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       q <= '0;
    else if (!load_n) q <= din;
    else if (run)     q <= nxt;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(din));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && (enp_n || ent_n)) |=> $stable(q));

  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !enp_n && !ent_n && up) |=> q == $past(q) + ONE);

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !enp_n && !ent_n && !up) |=> q == $past(q) - ONE);

  assert_carry_terminal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (!ent_n && (up ? (&q) : !(|q))));

  assert_carry_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ent_n |-> carry_n);
endmodule

// File: tb/updn_cascade_ctr_test.sv
`timescale 1ns/100ps
module updn_cascade_ctr_test;
  logic clk = 0;
  logic rst_n = 0;
  logic load_n = 1, up = 1, enp_n = 1, ent_n = 1;
  logic [3:0] din = 0;
  logic [3:0] q;
  logic carry_n;

  logic c_ld_n = 1, c_up = 1, c_en_n = 1;
  logic [7:0] c_din = 0;
  logic [3:0] lo_q, hi_q;
  logic lo_carry, hi_carry;

  int ntot = 0, npass = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  updn_cascade_ctr #(.WIDTH(4)) uut (.clk(clk), .rst_n(rst_n), .load_n(load_n),
    .din(din), .up(up), .enp_n(enp_n), .ent_n(ent_n), .q(q), .carry_n(carry_n));

  updn_cascade_ctr #(.WIDTH(4)) lo_stage (.clk(clk), .rst_n(rst_n), .load_n(c_ld_n),
    .din(c_din[3:0]), .up(c_up), .enp_n(c_en_n), .ent_n(c_en_n), .q(lo_q), .carry_n(lo_carry));

  updn_cascade_ctr #(.WIDTH(4)) hi_stage (.clk(clk), .rst_n(rst_n), .load_n(c_ld_n),
    .din(c_din[7:4]), .up(c_up), .enp_n(c_en_n), .ent_n(lo_carry), .q(hi_q), .carry_n(hi_carry));

  task automatic chk(input string tag, input int act, input int exp);
    ntot++;
    if (act == exp) npass++;
    else $display("FAIL %s: got %0d expected %0d", tag, act, exp);
  endtask

  task automatic step(input logic ld, input logic [3:0] d, input logic u,
                      input logic ep, input logic et);
    @(negedge clk);
    load_n = ld; din = d; up = u; enp_n = ep; ent_n = et;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 q in reset", q, 0);
    chk("R1 carry in reset", carry_n, 1);
    @(negedge clk); rst_n = 1;
    step(0, 4'd9, 1, 1, 1);
    chk("R2 load", q, 9);
    @(negedge clk); #1; rst_n = 0; #0.5;
    chk("R1 async clear", q, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_sequence;
    int exp_up[5] = '{14, 15, 0, 1, 2};
    int exp_dn[5] = '{1, 0, 15, 14, 13};
    step(0, 4'd13, 1, 1, 1);
    chk("R9 load 13", q, 13);
    for (int i = 0; i < 5; i++) begin
      step(1, 4'd0, 1, 0, 0);
      chk("R9 R4 count up", q, exp_up[i]);
      chk("R9 R5 carry up", carry_n, (exp_up[i] == 15) ? 0 : 1);
    end
    for (int i = 0; i < 3; i++) begin
      step(1, 4'd0, 1, 1, 1);
      chk("R9 R3 inhibit", q, 2);
      chk("R9 R5 carry inhibit", carry_n, 1);
    end
    for (int i = 0; i < 5; i++) begin
      step(1, 4'd0, 0, 0, 0);
      chk("R9 R4 count down", q, exp_dn[i]);
      chk("R9 R5 carry down", carry_n, (exp_dn[i] == 0) ? 0 : 1);
    end
  endtask

  task automatic t_priority_hold;
    step(0, 4'd6, 1, 0, 0);
    chk("R2 load beats enables", q, 6);
    step(0, 4'd11, 0, 1, 0);
    chk("R2 load with enp high", q, 11);
    step(1, 4'd0, 1, 1, 0);
    chk("R3 hold enp high", q, 11);
    step(1, 4'd0, 1, 0, 1);
    chk("R3 hold ent high", q, 11);
  endtask

  task automatic t_carry_comb;
    step(0, 4'd15, 1, 1, 1);
    @(negedge clk); #0.5;
    chk("R6 carry off with ent high", carry_n, 1);
    ent_n = 0; #0.5;
    chk("R6 carry on ent low", carry_n, 0);
    enp_n = 1; #0.2;
    chk("R5 enp no effect high", carry_n, 0);
    enp_n = 0; #0.2;
    chk("R5 enp no effect low", carry_n, 0);
    up = 0; #0.5;
    chk("R6 carry off on direction", carry_n, 1);
    @(negedge clk);
    load_n = 0; din = 0; ent_n = 1; enp_n = 1;
    @(posedge clk); #1;
    chk("R5 zero with ent high", carry_n, 1);
    ent_n = 0; #0.3;
    chk("R5 zero down carry", carry_n, 0);
    up = 1; #0.3;
    chk("R6 zero counting up", carry_n, 1);
  endtask

  task automatic t_midcycle;
    step(0, 4'd5, 1, 1, 1);
    @(negedge clk); load_n = 1;
    #0.5; load_n = 0; din = 4'd12; #0.5; load_n = 1;
    #0.3; enp_n = 0; ent_n = 0; #0.4; enp_n = 1; ent_n = 1;
    @(posedge clk); #1;
    chk("R7 pulses between edges", q, 5);
  endtask

  task automatic t_cascade;
    int r;
    @(negedge clk); c_ld_n = 0; c_din = 8'hFA; c_up = 1; c_en_n = 1;
    @(posedge clk); #1;
    chk("R8 cascade load", {hi_q, lo_q}, 8'hFA);
    r = 8'hFA;
    @(negedge clk); c_ld_n = 1; c_en_n = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      r = (r + 1) % 256;
      chk("R8 cascade up", {hi_q, lo_q}, r);
    end
    @(negedge clk); c_up = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      r = (r + 255) % 256;
      chk("R8 cascade down", {hi_q, lo_q}, r);
    end
    @(negedge clk); c_en_n = 1;
    @(posedge clk); #1;
    chk("R8 cascade hold", {hi_q, lo_q}, r);
  endtask

  initial begin
    t_reset;
    t_sequence;
    t_priority_hold;
    t_carry_comb;
    t_midcycle;
    t_cascade;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", npass, ntot);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      ntot++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", npass, ntot);
      $finish;
    end
  end
endmodule